// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block chooses at most one interrupt to accept each time a sampling strobe arrives. Two kinds of request take part. The first kind is a set of special sources whose rank is wired in. The second kind is a group of maskable peripheral sources, and each of these carries a 3-bit level that software sets. The whole peripheral group occupies one slot in the wired ranking. Five special sources sit above that slot: reset, non-maskable, debug break, clock-failure detect and watchdog. Two sit below it: single step and address match.

Inside the peripheral group, the programmable level is compared first. When two eligible peripherals have the same level, the one with the lower index wins. A peripheral counts only when three conditions hold: the global enable is set, its level is above the CPU's current priority level, and its level is not zero. Special sources ignore the enable and the CPU level.

The decision is registered on the strobe. The outputs are a one-cycle accept pulse, a source index and a level. The index and level hold until a later strobe finds a winner. A parameter selects between two equivalent peripheral comparison structures: a balanced tree or a linear scan.

Top module: `ipr_resolver`

## Requirements
- R1: After reset, `take_o`, `src_o` and `lvl_o` are all 0. `take_o` can be 1 only in the cycle after a cycle in which `sample_i` was 1.
- R2: In `spec_hi_i`, bit 0 is reset, bit 1 is non-maskable, bit 2 is debug break, bit 3 is clock-failure detect and bit 4 is watchdog. When any of these bits is set at a strobe, the lowest set bit wins and `src_o` equals that bit number. `lvl_o` is all ones. Neither `int_en_i` nor `cpu_ipl_i` affects this case.
- R3: In `spec_lo_i`, bit 0 is single step and bit 1 is address match. These sources are taken only when no high special source and no eligible peripheral is present. `src_o` is N+5 for single step and N+6 for address match, single step wins over address match, and `lvl_o` is all ones.
- R4: Peripheral i is eligible only when `per_req_i[i]` is 1, `int_en_i` is 1, and its level is strictly greater than `cpu_ipl_i`. The level of peripheral i is `per_lvl_i[3*i+:3]`.
- R5: A peripheral whose level is 0 is never accepted, even when `cpu_ipl_i` is 0.
- R6: When an eligible peripheral wins, the winner is the one with the highest level. `src_o` is 5+i and `lvl_o` is that peripheral's level.
- R7: When eligible peripherals tie on the highest level, the lowest index wins.
- R8: When a strobe finds nothing to accept, or when there is no strobe, `take_o` is 0 in the next cycle and `src_o` and `lvl_o` keep their values.
- R9: Both settings of `USE_TREE` give the same outputs for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sampling strobe |
| spec_hi_i | input | 5 | Special requests ranked above the peripheral group |
| spec_lo_i | input | 2 | Special requests ranked below the peripheral group |
| per_req_i | input | N | Peripheral request lines |
| per_lvl_i | input | N*LVL_W | Peripheral levels; peripheral i uses bits [LVL_W*i +: LVL_W] |
| cpu_ipl_i | input | LVL_W | Current CPU priority level |
| int_en_i | input | 1 | Global enable for maskable requests |
| take_o | output | 1 | One-cycle accept pulse |
| src_o | output | IDX_W | Index of the accepted source |
| lvl_o | output | LVL_W | Level of the accepted source |

## Verification
The hardest cases to reach are the ones where several eligible peripherals share the top level while the gating by `cpu_ipl_i` removes some of the other requests. Uniformly random levels seldom produce both a tie and an exact boundary such as level equal to `cpu_ipl_i`. To reach them, the random stimulus draws levels and CPU level from small ranges and makes special requests rare, so that the peripheral contest decides most strobes. Directed cases add exact ties, level equal to the CPU level, level zero, and single step against a weak peripheral. Two instances, one for each comparison structure, run side by side and are compared on every strobe.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
   localparam int N_HI = 5;
   localparam int N_LO = 2;

   typedef enum int {
      SP_RESET   = 0,
      SP_NMI     = 1,
      SP_DBG     = 2,
      SP_CLKFAIL = 3,
      SP_WDOG    = 4
   } spec_hi_e;

   typedef enum int {
      SP_STEP  = 0,
      SP_AMATCH = 1
   } spec_lo_e;
endpackage

// File: rtl/ipr_first_set.sv
module ipr_first_set #(
   parameter int W  = 5,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req_i,
   output logic          vld_o,
   output logic [IW-1:0] idx_o
);
   if (W < 1) begin : g_bad_w
      $error("ipr_first_set: W must be at least 1");
   end

   always_comb begin
      vld_o = 1'b0;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            vld_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/ipr_level_arb.sv
module ipr_level_arb #(
   parameter int N        = 8,
   parameter int LW       = 3,
   parameter bit USE_TREE = 1'b1,
   localparam int PIW     = $clog2(N)
) (
   input  logic [N-1:0]    req_i,
   input  logic [N*LW-1:0] lvl_i,
   input  logic [LW-1:0]   ipl_i,
   input  logic            en_i,
   output logic            vld_o,
   output logic [PIW-1:0]  idx_o,
   output logic [LW-1:0]   lvl_o
);
   if (N < 2) begin : g_bad_n
      $error("ipr_level_arb: N must be at least 2");
   end
   if (LW < 1) begin : g_bad_lw
      $error("ipr_level_arb: LW must be at least 1");
   end

   logic [N-1:0] elig;

   // level > ipl also rules out level 0
   for (genvar g = 0; g < N; g++) begin : g_elig
      assign elig[g] = req_i[g] && en_i && (lvl_i[g*LW +: LW] > ipl_i);
   end

   if (USE_TREE) begin : g_tree
      localparam int P     = 1 << PIW;
      localparam int NODES = 2 * P - 1;
      logic [NODES-1:0] nv;
      logic [LW-1:0]    nl [NODES];
      logic [PIW-1:0]   ni [NODES];

      for (genvar l = 0; l < P; l++) begin : g_leaf
         if (l < N) begin : g_real
            assign nv[P-1+l] = elig[l];
            assign nl[P-1+l] = lvl_i[l*LW +: LW];
            assign ni[P-1+l] = PIW'(l);
         end else begin : g_pad
            assign nv[P-1+l] = 1'b0;
            assign nl[P-1+l] = '0;
            assign ni[P-1+l] = '0;
         end
      end

      for (genvar k = 0; k < P - 1; k++) begin : g_node
         logic pick_l;
         // left child holds lower indices, so it wins ties
         assign pick_l = nv[2*k+1] && (!nv[2*k+2] || (nl[2*k+1] >= nl[2*k+2]));
         assign nv[k]  = nv[2*k+1] | nv[2*k+2];
         assign nl[k]  = pick_l ? nl[2*k+1] : nl[2*k+2];
         assign ni[k]  = pick_l ? ni[2*k+1] : ni[2*k+2];
      end

      assign vld_o = nv[0];
      assign idx_o = ni[0];
      assign lvl_o = nl[0];
   end else begin : g_linear
      always_comb begin
         vld_o = 1'b0;
         idx_o = '0;
         lvl_o = '0;
         // scan downward; >= lets the lower index take ties
         for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (!vld_o || lvl_i[i*LW +: LW] >= lvl_o)) begin
               vld_o = 1'b1;
               idx_o = PIW'(i);
               lvl_o = lvl_i[i*LW +: LW];
            end
         end
      end
   end
endmodule

// File: rtl/ipr_resolver.sv
module ipr_resolver
   import ipr_pkg::*;
#(
   parameter int N        = 8,
   parameter int LVL_W    = 3,
   parameter bit USE_TREE = 1'b1,
   localparam int PIW     = $clog2(N),
   localparam int NSRC    = N_HI + N + N_LO,
   localparam int IDX_W   = $clog2(NSRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_i,
   input  logic [N_HI-1:0]    spec_hi_i,
   input  logic [N_LO-1:0]    spec_lo_i,
   input  logic [N-1:0]       per_req_i,
   input  logic [N*LVL_W-1:0] per_lvl_i,
   input  logic [LVL_W-1:0]   cpu_ipl_i,
   input  logic               int_en_i,
   output logic               take_o,
   output logic [IDX_W-1:0]   src_o,
   output logic [LVL_W-1:0]   lvl_o
);
   localparam int HIW = $clog2(N_HI);
   localparam int LOW = (N_LO > 1) ? $clog2(N_LO) : 1;

   if (N < 2 || N > 64) begin : g_bad_n
      $error("ipr_resolver: N out of range 2..64");
   end

   logic           hi_vld, lo_vld, p_vld;
   logic [HIW-1:0] hi_idx;
   logic [LOW-1:0] lo_idx;
   logic [PIW-1:0] p_idx;
   logic [LVL_W-1:0] p_lvl;

   ipr_first_set #(.W(N_HI), .IW(HIW)) u_hi (
      .req_i(spec_hi_i), .vld_o(hi_vld), .idx_o(hi_idx)
   );

   ipr_first_set #(.W(N_LO), .IW(LOW)) u_lo (
      .req_i(spec_lo_i), .vld_o(lo_vld), .idx_o(lo_idx)
   );

   ipr_level_arb #(.N(N), .LW(LVL_W), .USE_TREE(USE_TREE)) u_arb (
      .req_i(per_req_i), .lvl_i(per_lvl_i), .ipl_i(cpu_ipl_i), .en_i(int_en_i),
      .vld_o(p_vld), .idx_o(p_idx), .lvl_o(p_lvl)
   );

   logic             win;
   logic [IDX_W-1:0] win_src;
   logic [LVL_W-1:0] win_lvl;

   // wired rank: high specials, peripheral group, low specials
   always_comb begin
      win     = 1'b1;
      win_src = '0;
      win_lvl = '1;
      if (hi_vld) begin
         win_src = IDX_W'(hi_idx);
      end else if (p_vld) begin
         win_src = IDX_W'(N_HI) + IDX_W'(p_idx);
         win_lvl = p_lvl;
      end else if (lo_vld) begin
         win_src = IDX_W'(N_HI + N) + IDX_W'(lo_idx);
      end else begin
         win     = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o <= 1'b0;
         src_o  <= '0;
         lvl_o  <= '0;
      end else begin
         take_o <= sample_i && win;
         if (sample_i && win) begin
            src_o <= win_src;
            lvl_o <= win_lvl;
         end
      end
   end

   // R1: no pulse without a strobe the cycle before
   a_r1_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_i |=> !take_o);

   // R8: outputs hold without a strobe
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_i |=> ($stable(src_o) && $stable(lvl_o)));

   // R2: high specials always taken, ranked below peripheral indices
   a_r2_special_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_i && (|spec_hi_i)) |=> (take_o && (lvl_o == '1) && (src_o < IDX_W'(N_HI))));

   // R4: with enable low only specials can be taken
   a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_i && !(|spec_hi_i) && !(|spec_lo_i) && !int_en_i) |=> !take_o);

   // R5: an accepted peripheral never carries level 0 or a level at or below the CPU level
   a_r5_periph_level: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_i && (|spec_hi_i) == 1'b0 && p_vld) |=>
         (take_o && lvl_o != '0 && lvl_o > $past(cpu_ipl_i)));
endmodule

// File: tb/sim_ipr_resolver.sv
`timescale 1ns/1ps
module sim_ipr_resolver;
   localparam int N  = 8;
   localparam int LW = 3;
   localparam int IW = $clog2(5 + N + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample_i = 1'b0;
   logic [4:0]    spec_hi_i = '0;
   logic [1:0]    spec_lo_i = '0;
   logic [N-1:0]  per_req_i = '0;
   logic [N*LW-1:0] per_lvl_i = '0;
   logic [LW-1:0] cpu_ipl_i = '0;
   logic          int_en_i = 1'b0;
   logic          take0, take1;
   logic [IW-1:0] src0, src1;
   logic [LW-1:0] lvl0, lvl1;

   always #2.5 clk = ~clk;

   ipr_resolver #(.N(N), .LVL_W(LW), .USE_TREE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .spec_hi_i(spec_hi_i),
      .spec_lo_i(spec_lo_i), .per_req_i(per_req_i), .per_lvl_i(per_lvl_i),
      .cpu_ipl_i(cpu_ipl_i), .int_en_i(int_en_i),
      .take_o(take0), .src_o(src0), .lvl_o(lvl0));

   ipr_resolver #(.N(N), .LVL_W(LW), .USE_TREE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .spec_hi_i(spec_hi_i),
      .spec_lo_i(spec_lo_i), .per_req_i(per_req_i), .per_lvl_i(per_lvl_i),
      .cpu_ipl_i(cpu_ipl_i), .int_en_i(int_en_i),
      .take_o(take1), .src_o(src1), .lvl_o(lvl1));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic          exp_take = 1'b0;
   logic [IW-1:0] exp_src  = '0;
   logic [LW-1:0] exp_lvl  = '0;

   task automatic chk(string tag, int got, int exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // reference model from the requirements; returns category 0 none,1 hi,2 periph,3 lo
   function automatic int model(output logic [IW-1:0] s, output logic [LW-1:0] l);
      int best = -1;
      int bl   = 0;
      s = '0; l = '1;
      for (int i = 0; i < 5; i++)
         if (spec_hi_i[i]) begin s = IW'(i); return 1; end
      for (int i = 0; i < N; i++) begin
         int lv = int'(per_lvl_i[i*LW +: LW]);
         if (per_req_i[i] && int_en_i && lv > int'(cpu_ipl_i) && lv > bl) begin
            best = i; bl = lv;
         end
      end
      if (best >= 0) begin s = IW'(5 + best); l = LW'(bl); return 2; end
      for (int i = 0; i < 2; i++)
         if (spec_lo_i[i]) begin s = IW'(5 + N + i); return 3; end
      return 0;
   endfunction

   // inputs are already set; drive strobe at negedge, check at next negedge
   task automatic step(bit smp, string tag);
      logic [IW-1:0] s;
      logic [LW-1:0] l;
      int cat;
      string t;
      sample_i = smp;
      cat = model(s, l);
      if (smp && cat != 0) begin
         exp_take = 1'b1; exp_src = s; exp_lvl = l;
      end else begin
         exp_take = 1'b0;
      end
      t = tag;
      if (t == "") begin
         if (!smp)          t = "R1";
         else if (cat == 1) t = "R2";
         else if (cat == 2) t = "R6";
         else if (cat == 3) t = "R3";
         else               t = "R8";
      end
      @(negedge clk);
      chk(t, int'(take0), int'(exp_take));
      chk(t, int'(src0),  int'(exp_src));
      chk(t, int'(lvl0),  int'(exp_lvl));
      chk("R9", int'({take1, src1, lvl1}), int'({take0, src0, lvl0}));
      sample_i = 1'b0;
   endtask

   task automatic clear();
      spec_hi_i = '0; spec_lo_i = '0; per_req_i = '0; per_lvl_i = '0;
      cpu_ipl_i = '0; int_en_i = 1'b1;
   endtask

   task automatic set_p(int i, int lv);
      per_req_i[i] = 1'b1;
      per_lvl_i[i*LW +: LW] = LW'(lv);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", int'(take0), 0);
      chk("R1", int'(src0), 0);
      chk("R1", int'(lvl0), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: NMI and watchdog together with a strong peripheral, enable off
      clear(); int_en_i = 1'b0; cpu_ipl_i = 3'd7;
      spec_hi_i = 5'b10010; set_p(0, 7);
      step(1'b1, "R2");
      // R1: no strobe, no pulse, hold
      step(1'b0, "R1");
      // R3: weak peripheral beats single step
      clear(); spec_lo_i = 2'b11; set_p(6, 1);
      step(1'b1, "R3");
      // R3: single step over address match
      clear(); spec_lo_i = 2'b11;
      step(1'b1, "R3");
      clear(); spec_lo_i = 2'b10;
      step(1'b1, "R3");
      // R4: level equal to CPU level is refused, hold
      clear(); cpu_ipl_i = 3'd3; set_p(4, 3);
      step(1'b1, "R4");
      set_p(5, 4);
      step(1'b1, "R4");
      // R4: enable off refuses peripherals
      clear(); int_en_i = 1'b0; set_p(1, 6);
      step(1'b1, "R4");
      // R5: level 0 with CPU level 0
      clear(); set_p(0, 0);
      step(1'b1, "R5");
      // R6: highest level wins
      clear(); set_p(1, 2); set_p(3, 6); set_p(7, 5);
      step(1'b1, "R6");
      // R7: tie goes to lower index
      clear(); set_p(5, 4); set_p(2, 4); set_p(6, 1);
      step(1'b1, "R7");
      clear(); for (int i = 0; i < N; i++) set_p(i, 7);
      step(1'b1, "R7");
      // R8: nothing requested, hold previous
      clear();
      step(1'b1, "R8");

      // constrained random mix
      for (int it = 0; it < 4000; it++) begin
         spec_hi_i = ($urandom % 10 == 0) ? 5'($urandom) : 5'd0;
         spec_lo_i = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
         per_req_i = N'($urandom) & N'($urandom);
         for (int i = 0; i < N; i++)
            per_lvl_i[i*LW +: LW] = ($urandom % 3 == 0) ? LW'($urandom) : LW'(2 + $urandom % 3);
         cpu_ipl_i = LW'($urandom % 5);
         int_en_i  = ($urandom % 5 != 0);
         step(($urandom % 6 != 0), "");
      end
      finish_run();
   end
endmodule